// File: doc/BRIEF.md
# NAND Flash Command Register Model

This block is the device side of a NAND flash bus: a synthesizable model of the command register, address counter, page register and busy logic that a host controller expects to find. Each clock the host may present one bus cycle. A write strobe with the command latch high writes a command byte. A write strobe with the address latch high writes an address byte. A write strobe with neither latch high writes a data byte. A read strobe asks for one byte on the data bus, and that byte appears one cycle later.

The model runs three jobs, each of which holds ready/busy low for a fixed, parameterized number of cycles: page program, page read and copy-back program. A reset command aborts any job. The cell array itself is not stored. A small tracker records, for each page, how many partial programs the main and spare areas have taken and whether copy-back has written the page. This is enough to report a pass or fail verdict in the status byte the way a real part would. The host can read the status byte at any time, even while a job is running. Tracking is cleared only by the reset pin, which stands for an erased array.

Top module: `nand_cmd_fsm`

## Requirements
- R1: After the reset pin is released, ready_o is 1 and dq_oe_o is 0, and a status read returns C0h.
- R2: A write with both latches high is ignored. A write with only the command latch high is a command, with only the address latch high is an address, and with neither latch high is data.
- R3: After 80h, 00h or 8Ah, exactly three address bytes are taken and any further address writes are ignored. Byte 1 is the column: its low bits set the page register pointer and its bit 7 selects the spare area. The low bits of byte 2 are the page number, and bit 0 of the page number is the plane.
- R4: 10h starts a program only if it follows 80h and three address bytes. In any other case it changes nothing.
- R5: ready_o goes low on the clock edge that accepts the job. It stays low for T_PROG cycles for a program or copy-back, for T_READ cycles for a read (00h followed by three address bytes), and for T_RESET cycles after FFh.
- R6: While ready_o is low, every command except 70h and FFh is ignored, and so are all address and data writes.
- R7: After 70h, every read returns the status byte until another accepted command arrives. Unknown codes and ignored commands leave status mode in place. The status byte is {1, ready, 00000, fail}.
- R8: Status bit 6 reads 0 while a job runs and 1 when the device is idle.
- R9: On each page, a third program to the main area fails, and so does a fourth program to the spare area. A program that fails does not add to the count. Status bit 0 shows the verdict of the last job to finish.
- R10: 8Ah is accepted only after a read has completed. The copy-back fails if the destination plane differs from the source plane. A successful copy-back makes every later program to the destination page fail.
- R11: FFh aborts any job, so an aborted program changes neither the page counts nor the fail bit. FFh also forgets the copy-back source and returns the model to idle.
- R12: Outside status mode, each read returns the page register byte at the pointer and then advances the pointer. 80h fills the page register with FFh, and each data write stores its byte at the pointer and advances it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears page tracking |
| cle_i | input | 1 | Command latch enable |
| ale_i | input | 1 | Address latch enable |
| wr_i | input | 1 | Write strobe, one bus write per cycle |
| rd_i | input | 1 | Read strobe, ignored while wr_i is high |
| dq_i | input | 8 | Byte written by the host |
| dq_o | output | 8 | Byte returned for a read, one cycle after the strobe |
| dq_oe_o | output | 1 | High for the cycle in which dq_o carries read data |
| ready_o | output | 1 | 1 = ready, 0 = busy |

## Verification
A wrong address count or mode shows up at the ports as soon as the host tries the command that depends on it: ready_o either falls on an edge where it should not, or fails to fall. A bad pointer corrupts the very next data read. A wrong page count or copy-back flag stays hidden until that page is programmed again, so the bench programs pages repeatedly up to and past their limits and then reads the verdict. The bench's reference model compares ready_o and every read byte on each clock, so a divergence is reported in the cycle in which it appears.

// File: rtl/nand_cmd_pkg.sv
package nand_cmd_pkg;

    localparam logic [7:0] CODE_LOAD    = 8'h80;
    localparam logic [7:0] CODE_CONFIRM = 8'h10;
    localparam logic [7:0] CODE_READ    = 8'h00;
    localparam logic [7:0] CODE_COPY    = 8'h8A;
    localparam logic [7:0] CODE_STATUS  = 8'h70;
    localparam logic [7:0] CODE_RESET   = 8'hFF;

    typedef enum logic [1:0] {
        CYC_NONE,
        CYC_CMD,
        CYC_ADDR,
        CYC_DATA
    } cyc_kind_e;

    typedef enum logic [2:0] {
        OPC_LOAD,
        OPC_CONFIRM,
        OPC_READ,
        OPC_COPY,
        OPC_STATUS,
        OPC_RESET,
        OPC_UNKNOWN
    } opcode_e;

    typedef enum logic [2:0] {
        MD_IDLE,
        MD_LOAD,
        MD_RDADDR,
        MD_CPADDR,
        MD_STATUS
    } mode_e;

    typedef enum logic [2:0] {
        JOB_NONE,
        JOB_PROG,
        JOB_READ,
        JOB_COPY,
        JOB_RST
    } job_e;

endpackage

// File: rtl/nand_bus_decode.sv
module nand_bus_decode
    import nand_cmd_pkg::*;
(
    input  logic      wr_i,
    input  logic      cle_i,
    input  logic      ale_i,
    input  logic [7:0] dq_i,
    output cyc_kind_e kind_o,
    output opcode_e   opc_o
);

    always_comb begin
        kind_o = CYC_NONE;
        if (wr_i) begin
            unique case ({cle_i, ale_i})
                2'b10:   kind_o = CYC_CMD;
                2'b01:   kind_o = CYC_ADDR;
                2'b00:   kind_o = CYC_DATA;
                default: kind_o = CYC_NONE;
            endcase
        end
    end

    always_comb begin
        unique case (dq_i)
            CODE_LOAD:    opc_o = OPC_LOAD;
            CODE_CONFIRM: opc_o = OPC_CONFIRM;
            CODE_READ:    opc_o = OPC_READ;
            CODE_COPY:    opc_o = OPC_COPY;
            CODE_STATUS:  opc_o = OPC_STATUS;
            CODE_RESET:   opc_o = OPC_RESET;
            default:      opc_o = OPC_UNKNOWN;
        endcase
    end

endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] val_i,
    output logic          busy_o,
    output logic          done_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
    assign done_o = (cnt_q == CW'(1));

    // R5: a job always asks for a non-empty busy window
    assert_load_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (val_i != '0));

    // R5: the last busy cycle is followed by ready unless a new job starts
    assert_done_then_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !load_i) |=> !busy_o);

    // R5: the window shrinks by exactly one per cycle
    assert_count_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/nand_page_track.sv
module nand_page_track #(
    parameter int PAGES       = 8,
    parameter int MAIN_LIMIT  = 2,
    parameter int SPARE_LIMIT = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(PAGES)-1:0] page_i,
    input  logic                     spare_i,
    input  logic                     prog_commit_i,
    input  logic                     copy_commit_i,
    output logic                     refuse_o
);

    localparam int PW = $clog2(PAGES);
    localparam int MW = $clog2(MAIN_LIMIT + 1);
    localparam int SW = $clog2(SPARE_LIMIT + 1);

    typedef struct packed {
        logic [PAGES-1:0][MW-1:0] main_cnt;
        logic [PAGES-1:0][SW-1:0] spare_cnt;
        logic [PAGES-1:0]         copied;
    } trk_t;

    trk_t t_d, t_q;
    logic main_full, spare_full;

    assign main_full  = (t_q.main_cnt[page_i]  >= MW'(MAIN_LIMIT));
    assign spare_full = (t_q.spare_cnt[page_i] >= SW'(SPARE_LIMIT));
    assign refuse_o   = t_q.copied[page_i] || (spare_i ? spare_full : main_full);

    always_comb begin
        t_d = t_q;
        if (prog_commit_i && !refuse_o) begin
            if (spare_i) t_d.spare_cnt[page_i] = t_q.spare_cnt[page_i] + 1'b1;
            else         t_d.main_cnt[page_i]  = t_q.main_cnt[page_i] + 1'b1;
        end
        if (copy_commit_i) begin
            t_d.copied[page_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    generate
        for (genvar g = 0; g < PAGES; g++) begin : g_pg
            // R9: no page count ever passes its limit
            assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (t_q.main_cnt[g] <= MW'(MAIN_LIMIT)) && (t_q.spare_cnt[g] <= SW'(SPARE_LIMIT)));
            // R10: a copied page stays locked until the reset pin
            assert_copy_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
                t_q.copied[g] |=> t_q.copied[g]);
        end
    endgenerate

    // R9: a refused program leaves the counts untouched
    assert_refused_no_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_commit_i && refuse_o) |=> ($stable(t_q.main_cnt) && $stable(t_q.spare_cnt)));

    logic unused_pw;
    assign unused_pw = (PW == 0);

endmodule

// File: rtl/nand_cmd_fsm.sv
module nand_cmd_fsm
    import nand_cmd_pkg::*;
#(
    parameter int T_PROG      = 20,
    parameter int T_READ      = 8,
    parameter int T_RESET     = 3,
    parameter int PAGES       = 8,
    parameter int BUF_BYTES   = 16,
    parameter int MAIN_LIMIT  = 2,
    parameter int SPARE_LIMIT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cle_i,
    input  logic       ale_i,
    input  logic       wr_i,
    input  logic       rd_i,
    input  logic [7:0] dq_i,
    output logic [7:0] dq_o,
    output logic       dq_oe_o,
    output logic       ready_o
);

    localparam int PAGE_W = $clog2(PAGES);
    localparam int BUF_W  = $clog2(BUF_BYTES);
    localparam int T_MAX  = (T_PROG > T_READ) ? ((T_PROG > T_RESET) ? T_PROG : T_RESET)
                                              : ((T_READ > T_RESET) ? T_READ : T_RESET);
    localparam int CW     = $clog2(T_MAX + 1);

    typedef struct packed {
        mode_e                     mode;
        logic [1:0]                acnt;
        logic                      spare;
        logic [PAGE_W-1:0]         page;
        job_e                      job;
        logic [PAGE_W-1:0]         job_page;
        logic                      job_spare;
        logic [PAGE_W-1:0]         src_page;
        logic                      src_ok;
        logic                      fail;
        logic [BUF_W-1:0]          ptr;
        logic [BUF_BYTES-1:0][7:0] pbuf;
        logic [7:0]                dq;
        logic                      oe;
    } fsm_st_t;

    fsm_st_t   s_d, s_q;
    cyc_kind_e kind;
    opcode_e   opc;
    logic      tmr_load, tmr_busy, tmr_done;
    logic [CW-1:0] tmr_val;
    logic      trk_refuse, prog_commit, copy_commit;
    logic      rst_cmd, plane_same, addr_mode;

    nand_bus_decode u_dec (
        .wr_i   (wr_i),
        .cle_i  (cle_i),
        .ale_i  (ale_i),
        .dq_i   (dq_i),
        .kind_o (kind),
        .opc_o  (opc)
    );

    nand_busy_timer #(.CW(CW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .busy_o (tmr_busy),
        .done_o (tmr_done)
    );

    nand_page_track #(
        .PAGES       (PAGES),
        .MAIN_LIMIT  (MAIN_LIMIT),
        .SPARE_LIMIT (SPARE_LIMIT)
    ) u_trk (
        .clk           (clk),
        .rst_n         (rst_n),
        .page_i        (s_q.job_page),
        .spare_i       (s_q.job_spare),
        .prog_commit_i (prog_commit),
        .copy_commit_i (copy_commit),
        .refuse_o      (trk_refuse)
    );

    assign rst_cmd    = (kind == CYC_CMD) && (opc == OPC_RESET);
    assign plane_same = (s_q.job_page[0] == s_q.src_page[0]);
    assign addr_mode  = (s_q.mode == MD_LOAD) || (s_q.mode == MD_RDADDR) || (s_q.mode == MD_CPADDR);

    always_comb begin
        s_d         = s_q;
        s_d.oe      = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        prog_commit = 1'b0;
        copy_commit = 1'b0;

        // job completion (an abort in the same cycle wins)
        if (tmr_done && !rst_cmd) begin
            case (s_q.job)
                JOB_PROG: begin
                    s_d.fail    = trk_refuse;
                    prog_commit = 1'b1;
                end
                JOB_COPY: begin
                    s_d.fail    = !plane_same;
                    copy_commit = plane_same;
                end
                JOB_READ: begin
                    s_d.src_ok   = 1'b1;
                    s_d.src_page = s_q.job_page;
                end
                default: ;
            endcase
            s_d.job = JOB_NONE;
        end

        case (kind)
            CYC_CMD: begin
                if (opc == OPC_RESET) begin
                    s_d.job    = JOB_RST;
                    s_d.mode   = MD_IDLE;
                    s_d.acnt   = '0;
                    s_d.src_ok = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_val    = CW'(T_RESET);
                end else if (opc == OPC_STATUS) begin
                    s_d.mode = MD_STATUS;
                end else if (!tmr_busy) begin
                    case (opc)
                        OPC_LOAD: begin
                            s_d.mode = MD_LOAD;
                            s_d.acnt = '0;
                            s_d.pbuf = '1;
                        end
                        OPC_READ: begin
                            s_d.mode = MD_RDADDR;
                            s_d.acnt = '0;
                        end
                        OPC_COPY: begin
                            if (s_q.src_ok) begin
                                s_d.mode = MD_CPADDR;
                                s_d.acnt = '0;
                            end
                        end
                        OPC_CONFIRM: begin
                            if (s_q.mode == MD_LOAD && s_q.acnt == 2'd3) begin
                                s_d.job       = JOB_PROG;
                                s_d.job_page  = s_q.page;
                                s_d.job_spare = s_q.spare;
                                s_d.mode      = MD_IDLE;
                                tmr_load      = 1'b1;
                                tmr_val       = CW'(T_PROG);
                            end
                        end
                        default: ;
                    endcase
                end
            end
            CYC_ADDR: begin
                if (!tmr_busy && addr_mode && s_q.acnt != 2'd3) begin
                    s_d.acnt = s_q.acnt + 2'd1;
                    case (s_q.acnt)
                        2'd0: begin
                            s_d.spare = dq_i[7];
                            s_d.ptr   = dq_i[BUF_W-1:0];
                        end
                        2'd1: begin
                            s_d.page = dq_i[PAGE_W-1:0];
                        end
                        default: begin
                            if (s_q.mode == MD_RDADDR) begin
                                s_d.job      = JOB_READ;
                                s_d.job_page = s_q.page;
                                s_d.mode     = MD_IDLE;
                                tmr_load     = 1'b1;
                                tmr_val      = CW'(T_READ);
                            end else if (s_q.mode == MD_CPADDR) begin
                                s_d.job      = JOB_COPY;
                                s_d.job_page = s_q.page;
                                s_d.mode     = MD_IDLE;
                                tmr_load     = 1'b1;
                                tmr_val      = CW'(T_PROG);
                            end
                        end
                    endcase
                end
            end
            CYC_DATA: begin
                if (!tmr_busy && s_q.mode == MD_LOAD && s_q.acnt == 2'd3) begin
                    s_d.pbuf[s_q.ptr] = dq_i;
                    s_d.ptr           = s_q.ptr + 1'b1;
                end
            end
            default: ;
        endcase

        if (rd_i && !wr_i) begin
            s_d.oe = 1'b1;
            if (s_q.mode == MD_STATUS) begin
                s_d.dq = {1'b1, !tmr_busy, 5'b00000, s_q.fail};
            end else begin
                s_d.dq  = s_q.pbuf[s_q.ptr];
                s_d.ptr = s_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mode <= MD_IDLE;
            s_q.job  <= JOB_NONE;
            s_q.pbuf <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign dq_o    = s_q.dq;
    assign dq_oe_o = s_q.oe;
    assign ready_o = !tmr_busy;

    // R5: busy only starts on a host write
    assert_busy_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_o) |-> $past(wr_i));

    // R4: a confirm outside a complete load sequence never starts a job
    assert_confirm_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && wr_i && cle_i && !ale_i && dq_i == CODE_CONFIRM &&
         !(s_q.mode == MD_LOAD && s_q.acnt == 2'd3)) |=> ready_o);

    // R6: address writes while busy leave the address counter alone
    assert_busy_blocks_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && wr_i && ale_i && !cle_i) |=> $stable(s_q.acnt));

    // R7: status mode holds until a command write
    assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MD_STATUS && !(wr_i && cle_i)) |=> (s_q.mode == MD_STATUS));

    // R8: the ready bit of a status read matches the ready pin of the strobe cycle
    assert_status_ready_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe_o && $past(s_q.mode == MD_STATUS)) |-> (dq_o[6] == $past(ready_o)));

    // R12: read data appears only after a read strobe without a write
    assert_read_echo_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_o |-> $past(rd_i && !wr_i));

endmodule

// File: tb/tb_nand_cmd_fsm.sv
module tb_nand_cmd_fsm;

    localparam int TP  = 20;
    localparam int TR  = 8;
    localparam int TRS = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cle_i = 1'b0, ale_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
    logic [7:0] dq_i = 8'h00;
    logic [7:0] dq_o;
    logic       dq_oe_o, ready_o;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    always #10 clk = ~clk;

    nand_cmd_fsm #(.T_PROG(TP), .T_READ(TR), .T_RESET(TRS)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cle_i   (cle_i),
        .ale_i   (ale_i),
        .wr_i    (wr_i),
        .rd_i    (rd_i),
        .dq_i    (dq_i),
        .dq_o    (dq_o),
        .dq_oe_o (dq_oe_o),
        .ready_o (ready_o)
    );

    // ---------------- behavioural reference model ----------------
    int       m_mode, m_acnt, m_page, m_job, m_jpage, m_src, m_ptr, m_timer;
    bit       m_spare, m_jspare, m_srcok, m_fail, m_oe;
    bit [7:0] m_dq;
    bit [7:0] m_buf [16];
    int       m_main [8];
    int       m_sp   [8];
    bit       m_cb   [8];

    function automatic bit m_refuse(int p, bit sp);
        if (m_cb[p]) return 1'b1;
        return sp ? (m_sp[p] >= 3) : (m_main[p] >= 2);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_acnt = 0; m_page = 0; m_job = 0; m_jpage = 0; m_src = 0;
            m_ptr = 0; m_timer = 0; m_spare = 0; m_jspare = 0; m_srcok = 0;
            m_fail = 0; m_oe = 0; m_dq = 0;
            foreach (m_buf[i]) m_buf[i] = 8'hFF;
            foreach (m_main[i]) begin m_main[i] = 0; m_sp[i] = 0; m_cb[i] = 0; end
        end else begin
            bit busy, done, is_cmd, is_adr, is_dat, is_rd, rstc, old_fail;
            int nt;
            busy   = (m_timer != 0);
            done   = (m_timer == 1);
            is_cmd = wr_i && cle_i && !ale_i;
            is_adr = wr_i && ale_i && !cle_i;
            is_dat = wr_i && !cle_i && !ale_i;
            is_rd  = rd_i && !wr_i;
            rstc   = is_cmd && dq_i == 8'hFF;
            old_fail = m_fail;
            nt = busy ? m_timer - 1 : 0;
            if (done && !rstc) begin
                if (m_job == 1) begin
                    m_fail = m_refuse(m_jpage, m_jspare);
                    if (!m_fail) begin
                        if (m_jspare) m_sp[m_jpage]++; else m_main[m_jpage]++;
                    end
                end else if (m_job == 3) begin
                    if ((m_jpage % 2) == (m_src % 2)) begin m_fail = 0; m_cb[m_jpage] = 1; end
                    else m_fail = 1;
                end else if (m_job == 2) begin
                    m_srcok = 1; m_src = m_jpage;
                end
                m_job = 0;
            end
            if (is_cmd) begin
                if (rstc) begin
                    m_job = 4; m_mode = 0; m_acnt = 0; m_srcok = 0; nt = TRS;
                end else if (dq_i == 8'h70) begin
                    m_mode = 4;
                end else if (!busy) begin
                    if (dq_i == 8'h80) begin
                        m_mode = 1; m_acnt = 0;
                        foreach (m_buf[i]) m_buf[i] = 8'hFF;
                    end else if (dq_i == 8'h00) begin
                        m_mode = 2; m_acnt = 0;
                    end else if (dq_i == 8'h8A && m_srcok) begin
                        m_mode = 3; m_acnt = 0;
                    end else if (dq_i == 8'h10 && m_mode == 1 && m_acnt == 3) begin
                        m_job = 1; m_jpage = m_page; m_jspare = m_spare; m_mode = 0; nt = TP;
                    end
                end
            end else if (is_adr) begin
                if (!busy && m_mode >= 1 && m_mode <= 3 && m_acnt < 3) begin
                    if (m_acnt == 0) begin m_spare = dq_i[7]; m_ptr = dq_i % 16; end
                    else if (m_acnt == 1) m_page = dq_i % 8;
                    else if (m_mode == 2) begin m_job = 2; m_jpage = m_page; m_mode = 0; nt = TR; end
                    else if (m_mode == 3) begin m_job = 3; m_jpage = m_page; m_mode = 0; nt = TP; end
                    m_acnt++;
                end
            end else if (is_dat) begin
                if (!busy && m_mode == 1 && m_acnt == 3) begin
                    m_buf[m_ptr] = dq_i; m_ptr = (m_ptr + 1) % 16;
                end
            end
            m_oe = is_rd;
            if (is_rd) begin
                if (m_mode == 4) m_dq = {1'b1, !busy, 5'b00000, old_fail};
                else begin m_dq = m_buf[m_ptr]; m_ptr = (m_ptr + 1) % 16; end
            end
            m_timer = nt;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            total++;
            if (ready_o !== (m_timer == 0)) begin
                bad++;
                $display("FAIL R5 ready actual=%0b expected=%0b", ready_o, (m_timer == 0));
            end
            total++;
            if (dq_oe_o !== m_oe || (m_oe && dq_o !== m_dq)) begin
                bad++;
                $display("FAIL R12 read actual=%0b/%0h expected=%0b/%0h", dq_oe_o, dq_o, m_oe, m_dq);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_cyc(input logic c, input logic a, input logic [7:0] b);
        wr_i = 1'b1; cle_i = c; ale_i = a; dq_i = b;
        @(negedge clk);
        wr_i = 1'b0; cle_i = 1'b0; ale_i = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b); wr_cyc(1'b1, 1'b0, b); endtask
    task automatic adr(input logic [7:0] b); wr_cyc(1'b0, 1'b1, b); endtask
    task automatic dat(input logic [7:0] b); wr_cyc(1'b0, 1'b0, b); endtask

    task automatic rd(output logic [7:0] v);
        rd_i = 1'b1;
        @(negedge clk);
        rd_i = 1'b0;
        v = dq_o;
    endtask

    task automatic wait_rdy(output int n);
        n = 0;
        while (!ready_o) begin n++; @(negedge clk); end
    endtask

    task automatic prog(input logic [7:0] col, input logic [7:0] pg, input logic [7:0] d);
        int n;
        cmd(8'h80); adr(col); adr(pg); adr(8'h00); dat(d); cmd(8'h10);
        wait_rdy(n);
    endtask

    task automatic status(output logic [7:0] v);
        cmd(8'h70); rd(v);
    endtask

    task automatic finish_run();
        ended = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 ready", ready_o, 1);
        check("R1 oe", dq_oe_o, 0);
        status(v); check("R1 status", v, 8'hC0);

        // R4 lone confirm, R7 unknown code keeps status mode
        cmd(8'h10); check("R4 lone confirm", ready_o, 1);
        cmd(8'h55); rd(v); check("R7 status sticky", v, 8'hC0);

        // R10 copy-back before any read is ignored
        cmd(8'h8A); adr(8'h00); adr(8'h01); adr(8'h00);
        check("R10 copy without source", ready_o, 1);
        rd(v); check("R7 still status", v, 8'hC0);

        // R3 extra address ignored, R5 program window
        cmd(8'h80); adr(8'h02); adr(8'h01); adr(8'h00); adr(8'h05);
        dat(8'hAA); dat(8'hBB); cmd(8'h10);
        wait_rdy(n); check("R5 program cycles", n, TP);

        // R5 read window, R3 column kept, R12 pointer walk and fill
        cmd(8'h00); adr(8'h02); adr(8'h01); adr(8'h00);
        wait_rdy(n); check("R5 read cycles", n, TR);
        rd(v); check("R3 first byte at column", v, 8'hAA);
        rd(v); check("R12 pointer advance", v, 8'hBB);
        rd(v); check("R12 filled byte", v, 8'hFF);

        // R8 busy bit, R6 command ignored while busy
        cmd(8'h80); adr(8'h00); adr(8'h01); adr(8'h00); dat(8'h11); cmd(8'h10);
        cmd(8'h70); rd(v); check("R8 busy status", v, 8'h80);
        cmd(8'h00); adr(8'h00);
        wait_rdy(n);
        rd(v); check("R6 status kept after busy", v, 8'hC0);

        // R9 main area limit
        prog(8'h00, 8'h01, 8'h22); status(v); check("R9 third main fails", v, 8'hC1);
        prog(8'h80, 8'h02, 8'h01); prog(8'h80, 8'h02, 8'h02); prog(8'h80, 8'h02, 8'h03);
        status(v); check("R9 third spare passes", v, 8'hC0);
        prog(8'h80, 8'h02, 8'h04); status(v); check("R9 fourth spare fails", v, 8'hC1);
        prog(8'h00, 8'h07, 8'h05); status(v); check("R9 verdict updates", v, 8'hC0);

        // R10 copy-back within plane, lock, plane mismatch
        cmd(8'h00); adr(8'h00); adr(8'h03); adr(8'h00); wait_rdy(n);
        cmd(8'h8A); adr(8'h00); adr(8'h05); adr(8'h00);
        check("R10 copy accepted", ready_o, 0);
        wait_rdy(n); check("R10 copy cycles", n, TP);
        status(v); check("R10 copy passes", v, 8'hC0);
        prog(8'h00, 8'h05, 8'h06); status(v); check("R10 copied page locked", v, 8'hC1);
        prog(8'h00, 8'h00, 8'h07); status(v); check("R10 other page passes", v, 8'hC0);
        cmd(8'h8A); adr(8'h00); adr(8'h04); adr(8'h00); wait_rdy(n);
        status(v); check("R10 plane mismatch fails", v, 8'hC1);

        // R11 abort
        cmd(8'h80); adr(8'h00); adr(8'h06); adr(8'h00); dat(8'h08); cmd(8'h10);
        repeat (5) @(negedge clk);
        cmd(8'hFF); wait_rdy(n); check("R11 reset cycles", n, TRS);
        status(v); check("R11 fail kept", v, 8'hC1);
        prog(8'h00, 8'h06, 8'h09); prog(8'h00, 8'h06, 8'h0A);
        status(v); check("R11 aborted program not counted", v, 8'hC0);
        cmd(8'h8A); adr(8'h00); adr(8'h03); adr(8'h00);
        check("R11 source forgotten", ready_o, 1);

        // R4 short address sequence, R2 both latches
        cmd(8'h80); adr(8'h00); adr(8'h00); cmd(8'h10);
        check("R4 confirm after two addresses", ready_o, 1);
        cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'h00);
        wr_cyc(1'b1, 1'b1, 8'h10);
        check("R2 both latches ignored", ready_o, 1);
        dat(8'h5A); cmd(8'h10); wait_rdy(n);
        status(v); check("R2 program passes", v, 8'hC0);
        cmd(8'h00); adr(8'h00); adr(8'h00); adr(8'h00); wait_rdy(n);
        rd(v); check("R2 data byte stored", v, 8'h5A);
        rd(v); check("R12 rest filled", v, 8'hFF);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule